// File: doc/BRIEF.md
# Disk FIFO DMA Request Controller

This block drives the DMA request line and handles transfer termination for a 16-byte data FIFO placed between a DMA host and a disk data engine. It observes the FIFO fill level and the disk engine's byte slots. From these it decides when to ask the host for service. Read transfers run disk-to-host and write transfers run host-to-disk, and the two directions use different assert and release points. A programmable threshold moves those points. All data movement is by DMA; there is no programmed-I/O path.

A transfer begins with an execution-start pulse and ends in one of three ways: a terminal count (TC) from the host, the end-of-track sector completing, or a FIFO underrun or overrun. If a write transfer ends before the sector is complete, the block finishes the sector itself. It strobes one zero-fill byte per remaining disk slot. The outcome is shown as a 2-bit status and a done flag, and both hold until the next execution start.

Top module: `fifo_dma_req`

## Requirements
- R1: After reset, dma_req_o, pad_o and done_o are 0 and term_o is 00.
- R2: An exec_start_i pulse with dir_i=1 (host-to-disk) raises dma_req_o in the following cycle.
- R3: Host-to-disk: dma_req_o falls one cycle after fifo_level_i reads 16. It rises again one cycle after fifo_level_i is at or below the threshold, and stays low while the level is above it.
- R4: Disk-to-host (dir_i=0): dma_req_o rises one cycle after fifo_level_i reaches 16 minus the threshold, and falls one cycle after fifo_level_i reads 0. With threshold 0 it rises only at 16.
- R5: Disk-to-host: the disk slot that writes the last byte of a sector raises dma_req_o in the next cycle, even when the level is below the trigger point.
- R6: In the cycle after tc_i, dma_req_o is 0, and it stays 0 until the next execution start.
- R7: Host-to-disk after a mid-sector TC: once the FIFO is empty, every disk slot drives pad_o high in that same cycle until the sector length is reached. The block then sets done_o with term_o=10 (padded partial sector).
- R8: Host-to-disk: if TC came before the disk side pulls the last byte of a sector from a non-empty FIFO, the block sets done_o with term_o=00 (normal) and issues no pad_o.
- R9: When the sector flagged by last_sector_i completes without TC, the block sets done_o with term_o=01 (abnormal). For writes this happens at the last disk pull. For reads it happens once the FIFO has drained to 0.
- R10: A write disk slot that finds the FIFO empty with no TC is padded, and the sector then ends with term_o=01. A read disk slot with the FIFO at 16 ends the transfer at once with term_o=01.
- R11: done_o and term_o hold their values until the next exec_start_i, which clears done_o and sets term_o to 00.
- R12: Disk-to-host: tc_i ends the transfer in the next cycle with done_o=1 and term_o=00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | Transfer direction, 1 = host-to-disk, 0 = disk-to-host; latched at start |
| thr_i | input | THR_W | Request threshold, 0 to 15 |
| sec_len_i | input | SEC_W | Bytes per sector |
| last_sector_i | input | 1 | Current sector is the end-of-track sector |
| exec_start_i | input | 1 | Execution phase start pulse |
| tc_i | input | 1 | Terminal count from the DMA host |
| disk_stb_i | input | 1 | Disk byte slot: pull (write) or push (read) |
| fifo_level_i | input | LVL_W | FIFO occupancy, 0 to 16 |
| dma_req_o | output | 1 | DMA request to the host |
| pad_o | output | 1 | Disk slot is filled with a zero byte |
| done_o | output | 1 | Transfer finished, status valid |
| term_o | output | 2 | 00 normal, 01 abnormal, 10 padded partial sector |

## Verification
The hardest case to reach is the padded partial sector. To get there, the write transfer must first pass a TC while bytes are still queued. The FIFO must then drain, and disk slots must keep arriving on an empty FIFO. The stimulus does this in order. It pulls two bytes of a four-byte sector, raises TC, and then drops the level to zero while the disk slots continue. The pad count and the 10 status can then be checked against the sector length.

// File: rtl/fdr_pkg.sv
package fdr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_PAD,
    ST_DRAIN,
    ST_DONE
  } fdr_state_e;

  typedef enum logic [1:0] {
    TERM_NORMAL   = 2'b00,
    TERM_ABNORMAL = 2'b01,
    TERM_PADDED   = 2'b10
  } fdr_term_e;

  localparam logic DIR_D2H = 1'b0;
  localparam logic DIR_H2D = 1'b1;
endpackage

// File: rtl/fdr_trig.sv
module fdr_trig #(
  parameter int DEPTH = 16,
  parameter int THR_W = 4,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             full_o,
  output logic             empty_o,
  output logic             rd_hit_o,
  output logic             wr_hit_o
);
  localparam int CW = ((LVL_W > THR_W) ? LVL_W : THR_W) + 1;
  localparam logic [CW-1:0] DEP_C = CW'(DEPTH);
  localparam logic [CW-1:0] MAX_C = CW'(DEPTH - 1);

  logic [CW-1:0] lvl_x;
  logic [CW-1:0] thr_x;
  logic [CW-1:0] thr_eff;
  logic [CW-1:0] rd_pt;

  assign lvl_x = CW'(level_i);
  assign thr_x = CW'(thr_i);

  // clamp keeps the read point at 1 or above and the write point below full
  generate
    if ((1 << THR_W) > DEPTH) begin : g_clamp
      assign thr_eff = (thr_x > MAX_C) ? MAX_C : thr_x;
    end else begin : g_direct
      assign thr_eff = thr_x;
    end
  endgenerate

  assign rd_pt    = DEP_C - thr_eff;
  assign full_o   = (lvl_x >= DEP_C);
  assign empty_o  = (lvl_x == '0);
  assign rd_hit_o = (lvl_x >= rd_pt);
  assign wr_hit_o = (lvl_x <= thr_eff);
endmodule

// File: rtl/fdr_seccnt.sv
module fdr_seccnt #(
  parameter int SEC_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [SEC_W-1:0] len_i,
  output logic             last_o
);
  logic [SEC_W-1:0] cnt_q;
  logic [SEC_W:0]   nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  // a zero length acts as a one-byte sector
  assign nxt    = {1'b0, cnt_q} + 1'b1;
  assign last_o = (nxt >= {1'b0, len_i});
endmodule

// File: rtl/fdr_ctrl.sv
module fdr_ctrl
  import fdr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dir_i,
  input  logic       exec_start_i,
  input  logic       tc_i,
  input  logic       disk_stb_i,
  input  logic       last_sector_i,
  input  logic       full_i,
  input  logic       empty_i,
  input  logic       rd_hit_i,
  input  logic       wr_hit_i,
  input  logic       sec_last_i,
  output logic       cnt_clr_o,
  output logic       cnt_inc_o,
  output logic       dma_req_o,
  output logic       pad_o,
  output logic       done_o,
  output logic [1:0] term_o
);
  fdr_state_e st_q, st_d;
  fdr_term_e  term_q, term_d, pend_q, pend_d;
  logic       req_q, req_d;
  logic       tcs_q, tcs_d;
  logic       dir_q, dir_d;
  logic       tc_any;
  logic       rd_set;

  assign tc_any = tc_i | tcs_q;

  always_comb begin
    st_d      = st_q;
    term_d    = term_q;
    pend_d    = pend_q;
    req_d     = req_q;
    tcs_d     = tcs_q;
    dir_d     = dir_q;
    pad_o     = 1'b0;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    rd_set    = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (exec_start_i) begin
          st_d      = ST_XFER;
          dir_d     = dir_i;
          req_d     = (dir_i == DIR_H2D);
          term_d    = TERM_NORMAL;
          pend_d    = TERM_NORMAL;
          tcs_d     = 1'b0;
          cnt_clr_o = 1'b1;
        end
      end
      ST_XFER: begin
        if (dir_q == DIR_H2D) begin
          if (tc_i) tcs_d = 1'b1;
          if (tc_any)        req_d = 1'b0;
          else if (full_i)   req_d = 1'b0;
          else if (wr_hit_i) req_d = 1'b1;
          if (disk_stb_i) begin
            if (empty_i) begin
              // host stopped mid-sector: fill with zeros
              pad_o  = 1'b1;
              req_d  = 1'b0;
              pend_d = tc_any ? TERM_PADDED : TERM_ABNORMAL;
              if (sec_last_i) begin
                st_d   = ST_DONE;
                term_d = pend_d;
              end else begin
                st_d      = ST_PAD;
                cnt_inc_o = 1'b1;
              end
            end else if (sec_last_i) begin
              cnt_clr_o = 1'b1;
              if (tc_any) begin
                st_d   = ST_DONE;
                term_d = TERM_NORMAL;
                req_d  = 1'b0;
              end else if (last_sector_i) begin
                st_d   = ST_DONE;
                term_d = TERM_ABNORMAL;
                req_d  = 1'b0;
              end
            end else begin
              cnt_inc_o = 1'b1;
            end
          end
        end else begin
          if (tc_i) begin
            st_d   = ST_DONE;
            term_d = TERM_NORMAL;
            req_d  = 1'b0;
          end else if (disk_stb_i && full_i) begin
            st_d   = ST_DONE;
            term_d = TERM_ABNORMAL;
            req_d  = 1'b0;
          end else begin
            rd_set = rd_hit_i;
            if (disk_stb_i) begin
              if (sec_last_i) begin
                rd_set    = 1'b1;
                cnt_clr_o = 1'b1;
                if (last_sector_i) st_d = ST_DRAIN;
              end else begin
                cnt_inc_o = 1'b1;
              end
            end
            if (rd_set)       req_d = 1'b1;
            else if (empty_i) req_d = 1'b0;
          end
        end
      end
      ST_PAD: begin
        req_d = 1'b0;
        if (disk_stb_i) begin
          pad_o = 1'b1;
          if (sec_last_i) begin
            st_d      = ST_DONE;
            term_d    = pend_q;
            cnt_clr_o = 1'b1;
          end else begin
            cnt_inc_o = 1'b1;
          end
        end
      end
      ST_DRAIN: begin
        if (tc_i) begin
          st_d   = ST_DONE;
          term_d = TERM_NORMAL;
          req_d  = 1'b0;
        end else if (empty_i) begin
          st_d   = ST_DONE;
          term_d = TERM_ABNORMAL;
          req_d  = 1'b0;
        end else begin
          req_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      term_q <= TERM_NORMAL;
      pend_q <= TERM_NORMAL;
      req_q  <= 1'b0;
      tcs_q  <= 1'b0;
      dir_q  <= DIR_D2H;
    end else begin
      st_q   <= st_d;
      term_q <= term_d;
      pend_q <= pend_d;
      req_q  <= req_d;
      tcs_q  <= tcs_d;
      dir_q  <= dir_d;
    end
  end

  assign dma_req_o = req_q;
  assign done_o    = (st_q == ST_DONE);
  assign term_o    = term_q;
endmodule

// File: rtl/fifo_dma_req.sv
module fifo_dma_req #(
  parameter int DEPTH = 16,
  parameter int THR_W = 4,
  parameter int SEC_W = 10,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic [SEC_W-1:0] sec_len_i,
  input  logic             last_sector_i,
  input  logic             exec_start_i,
  input  logic             tc_i,
  input  logic             disk_stb_i,
  input  logic [LVL_W-1:0] fifo_level_i,
  output logic             dma_req_o,
  output logic             pad_o,
  output logic             done_o,
  output logic [1:0]       term_o
);
  logic full, empty, rd_hit, wr_hit;
  logic sec_last, cnt_clr, cnt_inc;

  fdr_trig #(.DEPTH(DEPTH), .THR_W(THR_W), .LVL_W(LVL_W)) u_trig (
    .level_i (fifo_level_i),
    .thr_i   (thr_i),
    .full_o  (full),
    .empty_o (empty),
    .rd_hit_o(rd_hit),
    .wr_hit_o(wr_hit)
  );

  fdr_seccnt #(.SEC_W(SEC_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .len_i (sec_len_i),
    .last_o(sec_last)
  );

  fdr_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dir_i        (dir_i),
    .exec_start_i (exec_start_i),
    .tc_i         (tc_i),
    .disk_stb_i   (disk_stb_i),
    .last_sector_i(last_sector_i),
    .full_i       (full),
    .empty_i      (empty),
    .rd_hit_i     (rd_hit),
    .wr_hit_i     (wr_hit),
    .sec_last_i   (sec_last),
    .cnt_clr_o    (cnt_clr),
    .cnt_inc_o    (cnt_inc),
    .dma_req_o    (dma_req_o),
    .pad_o        (pad_o),
    .done_o       (done_o),
    .term_o       (term_o)
  );
endmodule

// File: rtl/fdr_checker.sv
module fdr_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       dir_i,
  input logic       exec_start_i,
  input logic       tc_i,
  input logic       disk_stb_i,
  input logic       dma_req_o,
  input logic       pad_o,
  input logic       done_o,
  input logic [1:0] term_o
);
  AST_NO_REQ_AFTER_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_i && !exec_start_i) |=> !dma_req_o); // R6

  AST_WR_START_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_start_i && dir_i && !dma_req_o && !pad_o && (done_o || term_o == 2'b00)) |=> dma_req_o); // R2

  AST_PAD_ON_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_o |-> disk_stb_i); // R7

  AST_PAD_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_o |=> !dma_req_o); // R7

  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !exec_start_i) |=> (done_o && $stable(term_o))); // R11

  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!dma_req_o && !pad_o)); // R11

  AST_TERM_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o != 2'b11); // R9
endmodule

bind fifo_dma_req fdr_checker u_fdr_checker (.*);

// File: tb/tb_fifo_dma_req.sv
module tb_fifo_dma_req;
  localparam int SEL_REQ = 0, SEL_PAD = 1, SEL_DONE = 2, SEL_TERM = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir = 1'b0;
  logic [3:0] thr = 4'd4;
  logic [9:0] sec_len = 10'd4;
  logic       last_sec = 1'b0;
  logic       start = 1'b0;
  logic       tc = 1'b0;
  logic       dstb = 1'b0;
  logic [4:0] level = 5'd0;
  logic       req, pad, done;
  logic [1:0] term;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  typedef struct {
    string      tag;
    int         sel;
    logic [1:0] val;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  fifo_dma_req dut (
    .clk_i(clk), .rst_ni(rst_n), .dir_i(dir), .thr_i(thr), .sec_len_i(sec_len),
    .last_sector_i(last_sec), .exec_start_i(start), .tc_i(tc), .disk_stb_i(dstb),
    .fifo_level_i(level), .dma_req_o(req), .pad_o(pad), .done_o(done), .term_o(term)
  );

  task automatic tick();
    @(posedge clk);
    #1;
    start = 1'b0;
    tc    = 1'b0;
    dstb  = 1'b0;
  endtask

  task automatic exp_o(string tag, int sel, logic [1:0] val);
    q.push_back('{tag: tag, sel: sel, val: val});
  endtask

  // monitor: compares expectations pushed in the current cycle
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t it;
        logic [1:0] act;
        it = q.pop_front();
        case (it.sel)
          SEL_REQ:  act = {1'b0, req};
          SEL_PAD:  act = {1'b0, pad};
          SEL_DONE: act = {1'b0, done};
          default:  act = term;
        endcase
        checks++;
        if (act !== it.val) begin
          fails++;
          $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.tag, it.sel, act, it.val);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    exp_o("R1 req", SEL_REQ, 0);
    exp_o("R1 pad", SEL_PAD, 0);
    exp_o("R1 done", SEL_DONE, 0);
    exp_o("R1 term", SEL_TERM, 0);

    // write, mid-sector TC then padding
    dir = 1'b1; thr = 4'd4; sec_len = 10'd4; level = 5'd0; start = 1'b1;
    exp_o("R2 req before start", SEL_REQ, 0);
    tick();
    exp_o("R2 req after start", SEL_REQ, 1);
    level = 5'd16;
    tick();
    exp_o("R3 drop at full", SEL_REQ, 0);
    level = 5'd10;
    tick();
    exp_o("R3 stay low above thr", SEL_REQ, 0);
    level = 5'd4;
    tick();
    exp_o("R3 reassert at thr", SEL_REQ, 1);
    dstb = 1'b1;
    exp_o("R7 no pad with data", SEL_PAD, 0);
    tick();
    dstb = 1'b1;
    tick();
    tc = 1'b1;
    tick();
    exp_o("R6 req low after tc", SEL_REQ, 0);
    level = 5'd0; dstb = 1'b1;
    exp_o("R7 pad on empty slot", SEL_PAD, 1);
    tick();
    exp_o("R6 req stays low", SEL_REQ, 0);
    dstb = 1'b1;
    exp_o("R7 pad second slot", SEL_PAD, 1);
    tick();
    exp_o("R7 done", SEL_DONE, 1);
    exp_o("R7 term padded", SEL_TERM, 2);
    dstb = 1'b1;
    exp_o("R7 no pad after sector", SEL_PAD, 0);
    tick();
    level = 5'd5;
    tick();
    exp_o("R11 done held", SEL_DONE, 1);
    exp_o("R11 term held", SEL_TERM, 2);
    exp_o("R6 req low in done", SEL_REQ, 0);

    // write, end-of-track sector
    last_sec = 1'b1; sec_len = 10'd2; level = 5'd0; start = 1'b1;
    tick();
    exp_o("R11 done cleared", SEL_DONE, 0);
    exp_o("R11 term cleared", SEL_TERM, 0);
    exp_o("R2 req on restart", SEL_REQ, 1);
    level = 5'd3; dstb = 1'b1;
    tick();
    dstb = 1'b1;
    tick();
    exp_o("R9 write eot done", SEL_DONE, 1);
    exp_o("R9 write eot term", SEL_TERM, 1);

    // write, TC at sector boundary
    last_sec = 1'b0; sec_len = 10'd2; level = 5'd0; start = 1'b1;
    tick();
    tc = 1'b1;
    tick();
    exp_o("R6 req low tc", SEL_REQ, 0);
    level = 5'd2; dstb = 1'b1;
    exp_o("R8 no pad", SEL_PAD, 0);
    tick();
    dstb = 1'b1;
    exp_o("R8 no pad last", SEL_PAD, 0);
    tick();
    exp_o("R8 done", SEL_DONE, 1);
    exp_o("R8 term normal", SEL_TERM, 0);

    // write, underrun without TC
    sec_len = 10'd3; level = 5'd0; start = 1'b1;
    tick();
    dstb = 1'b1;
    exp_o("R10 underrun pad", SEL_PAD, 1);
    tick();
    dstb = 1'b1;
    exp_o("R10 pad 2", SEL_PAD, 1);
    tick();
    dstb = 1'b1;
    exp_o("R10 pad 3", SEL_PAD, 1);
    tick();
    exp_o("R10 underrun done", SEL_DONE, 1);
    exp_o("R10 underrun term", SEL_TERM, 1);

    // read, threshold points
    dir = 1'b0; thr = 4'd4; sec_len = 10'd100; level = 5'd0; start = 1'b1;
    tick();
    exp_o("R4 read start no req", SEL_REQ, 0);
    level = 5'd11;
    tick();
    exp_o("R4 below point", SEL_REQ, 0);
    level = 5'd12;
    tick();
    exp_o("R4 at point", SEL_REQ, 1);
    level = 5'd5;
    tick();
    exp_o("R4 held while draining", SEL_REQ, 1);
    level = 5'd0;
    tick();
    exp_o("R4 drop at empty", SEL_REQ, 0);

    // read, sector end flush
    sec_len = 10'd3; level = 5'd0; dstb = 1'b1;
    tick();
    exp_o("R5 byte 1", SEL_REQ, 0);
    level = 5'd1; dstb = 1'b1;
    tick();
    exp_o("R5 byte 2", SEL_REQ, 0);
    level = 5'd2; dstb = 1'b1;
    tick();
    exp_o("R5 last byte req", SEL_REQ, 1);
    level = 5'd3;
    tick();
    exp_o("R5 req held", SEL_REQ, 1);
    level = 5'd0;
    tick();
    exp_o("R5 drop at empty", SEL_REQ, 0);

    // read, overrun
    level = 5'd16; dstb = 1'b1;
    tick();
    exp_o("R10 overrun done", SEL_DONE, 1);
    exp_o("R10 overrun term", SEL_TERM, 1);
    exp_o("R10 overrun req", SEL_REQ, 0);

    // read, end-of-track drain
    last_sec = 1'b1; sec_len = 10'd2; level = 5'd0; start = 1'b1;
    tick();
    dstb = 1'b1;
    tick();
    exp_o("R9 read byte 1", SEL_REQ, 0);
    level = 5'd1; dstb = 1'b1;
    tick();
    exp_o("R9 read last req", SEL_REQ, 1);
    exp_o("R9 not done yet", SEL_DONE, 0);
    level = 5'd2;
    tick();
    exp_o("R9 drain req", SEL_REQ, 1);
    level = 5'd0;
    tick();
    exp_o("R9 read eot done", SEL_DONE, 1);
    exp_o("R9 read eot term", SEL_TERM, 1);
    exp_o("R9 read eot req", SEL_REQ, 0);

    // read, TC
    last_sec = 1'b0; sec_len = 10'd100; level = 5'd13; start = 1'b1;
    tick();
    tick();
    exp_o("R12 req before tc", SEL_REQ, 1);
    tc = 1'b1;
    tick();
    exp_o("R12 req after tc", SEL_REQ, 0);
    exp_o("R12 done", SEL_DONE, 1);
    exp_o("R12 term normal", SEL_TERM, 0);
    tick();
    tick();
    exp_o("R6 req stays low read", SEL_REQ, 0);

    // read, threshold 0 asserts only at full
    thr = 4'd0; level = 5'd15; start = 1'b1;
    tick();
    tick();
    exp_o("R4 thr0 at 15", SEL_REQ, 0);
    level = 5'd16;
    tick();
    exp_o("R4 thr0 at 16", SEL_REQ, 1);
    tc = 1'b1;
    tick();

    tick();
    tick();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule